// File: doc/BRIEF.md
# Spatial Pixel Watermark Embedder

This block is the arithmetic heart of a spatial-domain image watermark inserter. Each cycle it takes one 8-bit grayscale pixel and the three pixels that lie to its right, below it, and diagonally below-right. It also takes a 2-bit watermark symbol and two 8-bit fractional strength constants. From these it produces the watermarked pixel one cycle later, together with a write strobe that tells the surrounding image store whether the pixel must be written back.

Two embedding styles share one output path, and a mode pin picks between them. In the robust style, the pixel is mixed with a local neighbourhood mean. That mean is built from adders and one-bit right shifts only, with no divider. The ternary symbol then selects one of three actions: leave the pixel alone, blend with the scaled pixel added, or blend with the negative-strength term subtracted. Any sum above 255 clamps to 255. In the fragile style, one fixed bit plane of the pixel is XORed with the watermark bit, and every other bit passes through. Storage, addressing, symbol generation and detection all belong to neighbouring blocks.

Top module: `wm_pixel_embed`

## Requirements
- R1: With mode_robust=1 and wm_sym=0, out_pix equals pix_cur and out_we is 0.
- R2: The neighbourhood mean is NB = ((((pix_below + pix_diag) >> 1) + pix_right) >> 1), computed with 9-bit intermediate sums. With alpha1=0 and pix_cur=0, a robust symbol-1 output equals NB.
- R3: With mode_robust=1 and wm_sym=1, out_pix = min(255, ((NB*(256-alpha1))>>8) + ((pix_cur*alpha1)>>8)), and out_we is 1.
- R4: With mode_robust=1 and wm_sym=2, the hardware subtracts the negative strength term (operand inverted, carry-in 1). alpha2_mag holds the magnitude of that negative constant, so out_pix = min(255, ((NB*(256-alpha1))>>8) + ((pix_cur*alpha2_mag)>>8)), and out_we is 1.
- R5: A robust sum above 255 is output as exactly 255, and a robust symbol-1 or symbol-2 output is never below the scaled neighbourhood term.
- R6: With mode_robust=0, out_pix equals pix_cur with bit 2 XORed with wm_sym[0]. wm_sym[1] is ignored, and out_we is 1 for every valid pixel.
- R7: mode_robust=1 selects robust embedding and mode_robust=0 selects fragile embedding, both on the same out_pix port.
- R8: Outputs appear one clock after a cycle with in_valid=1, and out_valid follows in_valid with that one-cycle delay. After a cycle with in_valid=0, out_valid and out_we are 0 and out_pix keeps its previous value.
- R9: With mode_robust=1 and wm_sym=3 (reserved), the pixel passes through unchanged and out_we is 0.
- R10: Synchronous active-high reset clears out_valid, out_we and out_pix to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel set is valid this cycle |
| mode_robust | input | 1 | 1 = robust blend, 0 = fragile bit-plane flip |
| wm_sym | input | 2 | Watermark symbol (0 keep, 1 add, 2 subtract, 3 reserved); bit 0 is the fragile bit |
| alpha1 | input | 8 | Positive strength constant, fraction of 256 |
| alpha2_mag | input | 8 | Magnitude of the negative strength constant, fraction of 256 |
| pix_cur | input | 8 | Pixel at (i,j) |
| pix_right | input | 8 | Pixel at (i,j+1) |
| pix_below | input | 8 | Pixel at (i+1,j) |
| pix_diag | input | 8 | Pixel at (i+1,j+1) |
| out_valid | output | 1 | Registered result valid |
| out_we | output | 1 | Write-back strobe for out_pix |
| out_pix | output | 8 | Watermarked pixel |

## Verification
Some properties are checked on every cycle. The assertions cover: the one-cycle valid pipeline; exact pass-through with no write strobe for symbol 0; the fragile flip, which touches only bit 2 and always strobes; the neighbourhood mean staying within the range of its three inputs; and clamped robust outputs never falling below the scaled neighbourhood term. The exact blend values are checked only by the bench scenarios, against a model written from the formulas. These cover rounding of the two truncated products, the subtract-through-inversion path for symbol 2, saturation at 255, the reserved symbol, and holding of the output pixel while idle.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic [1:0] {
    SYM_KEEP = 2'd0,
    SYM_ADD  = 2'd1,
    SYM_SUB  = 2'd2,
    SYM_RSVD = 2'd3
  } wm_sym_e;
endpackage

// File: rtl/wm_nbr_mean.sv
module wm_nbr_mean #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] p_right,
  input  logic [PIX_W-1:0] p_below,
  input  logic [PIX_W-1:0] p_diag,
  output logic [PIX_W-1:0] mean
);
  localparam int SW = PIX_W + 1;

  logic [SW-1:0]    sum_lo;
  logic [PIX_W-1:0] half_lo;
  logic [SW-1:0]    sum_all;
  logic [PIX_W-1:0] lo_min, lo_max;

  always_comb begin
    sum_lo  = {1'b0, p_below} + {1'b0, p_diag};
    half_lo = PIX_W'(sum_lo >> 1);
    sum_all = {1'b0, half_lo} + {1'b0, p_right};
    mean    = PIX_W'(sum_all >> 1);
  end

  // R2: mean of the three neighbours must lie within their range
  always_comb begin
    lo_min = p_right;
    lo_max = p_right;
    if (p_below < lo_min) lo_min = p_below;
    if (p_diag  < lo_min) lo_min = p_diag;
    if (p_below > lo_max) lo_max = p_below;
    if (p_diag  > lo_max) lo_max = p_diag;
    assert_avg_bounded_R2: assert (mean >= lo_min && mean <= lo_max);
  end
endmodule

// File: rtl/wm_frac_scale.sv
module wm_frac_scale #(
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter int FRAC_W = 8
) (
  input  logic [DW-1:0]           data,
  input  logic [CW-1:0]           coef,
  output logic [DW+CW-FRAC_W-1:0] scaled
);
  localparam int PW = DW + CW;

  logic [PW-1:0] prod;

  always_comb begin
    prod   = PW'(data) * PW'(coef);
    scaled = (DW+CW-FRAC_W)'(prod >> FRAC_W);
  end
endmodule

// File: rtl/wm_blend_sat.sv
module wm_blend_sat #(
  parameter int PIX_W = 8,
  parameter int NW    = 9
) (
  input  logic [NW-1:0]    n_term,
  input  logic [PIX_W-1:0] p_term,
  input  logic             do_sub,
  output logic [PIX_W-1:0] result
);
  localparam int AW = PIX_W + 2;
  localparam logic [AW-1:0] PIX_MAX = AW'((1 << PIX_W) - 1);

  logic [AW-1:0] op_a, op_p, op_neg, op_b, acc;
  logic          cin;

  always_comb begin
    op_a   = AW'(n_term);
    op_p   = AW'(p_term);
    // subtract path: operand holds the signed (negative) term, inverted with carry in
    op_neg = ~op_p + AW'(1);
    op_b   = do_sub ? ~op_neg : op_p;
    cin    = do_sub;
    acc    = op_a + op_b + AW'(cin);
    result = (acc > PIX_MAX) ? PIX_MAX[PIX_W-1:0] : acc[PIX_W-1:0];
  end
endmodule

// File: rtl/wm_plane_flip.sv
module wm_plane_flip #(
  parameter int PIX_W = 8,
  parameter int PLANE = 2
) (
  input  logic [PIX_W-1:0] pix,
  input  logic             wbit,
  output logic [PIX_W-1:0] flipped
);
  logic [PIX_W-1:0] mask;

  always_comb begin
    mask    = PIX_W'(wbit) << PLANE;
    flipped = pix ^ mask;
  end
endmodule

// File: rtl/wm_pixel_embed.sv
module wm_pixel_embed
  import wm_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8,
  parameter int PLANE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              mode_robust,
  input  logic [1:0]        wm_sym,
  input  logic [FRAC_W-1:0] alpha1,
  input  logic [FRAC_W-1:0] alpha2_mag,
  input  logic [PIX_W-1:0]  pix_cur,
  input  logic [PIX_W-1:0]  pix_right,
  input  logic [PIX_W-1:0]  pix_below,
  input  logic [PIX_W-1:0]  pix_diag,
  output logic              out_valid,
  output logic              out_we,
  output logic [PIX_W-1:0]  out_pix
);
  localparam int CW  = FRAC_W + 1;
  localparam int NW  = PIX_W + CW - FRAC_W;
  localparam int PTW = PIX_W;

  wm_sym_e           sym;
  logic [CW-1:0]     comp_a1;
  logic [PIX_W-1:0]  nb_mean;
  logic [NW-1:0]     n_term;
  logic [FRAC_W-1:0] p_coef;
  logic [PTW-1:0]    p_term;
  logic [PIX_W-1:0]  blended, flipped;
  logic              strobe_robust;
  logic [PIX_W-1:0]  next_pix;
  logic              next_we;

  assign sym     = wm_sym_e'(wm_sym);
  assign comp_a1 = CW'(1 << FRAC_W) - CW'(alpha1);
  assign p_coef  = (sym == SYM_SUB) ? alpha2_mag : alpha1;

  wm_nbr_mean #(.PIX_W(PIX_W)) u_mean (
    .p_right(pix_right), .p_below(pix_below), .p_diag(pix_diag), .mean(nb_mean)
  );

  wm_frac_scale #(.DW(PIX_W), .CW(CW), .FRAC_W(FRAC_W)) u_scale_nb (
    .data(nb_mean), .coef(comp_a1), .scaled(n_term)
  );

  wm_frac_scale #(.DW(PIX_W), .CW(FRAC_W), .FRAC_W(FRAC_W)) u_scale_px (
    .data(pix_cur), .coef(p_coef), .scaled(p_term)
  );

  wm_blend_sat #(.PIX_W(PIX_W), .NW(NW)) u_blend (
    .n_term(n_term), .p_term(p_term), .do_sub(sym == SYM_SUB), .result(blended)
  );

  wm_plane_flip #(.PIX_W(PIX_W), .PLANE(PLANE)) u_flip (
    .pix(pix_cur), .wbit(wm_sym[0]), .flipped(flipped)
  );

  always_comb begin
    strobe_robust = (sym == SYM_ADD) || (sym == SYM_SUB);
    if (mode_robust) begin
      next_pix = strobe_robust ? blended : pix_cur;
      next_we  = strobe_robust;
    end else begin
      next_pix = flipped;
      next_we  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_valid & next_we;
      if (in_valid) out_pix <= next_pix;
    end
  end

  // R8: valid pipeline of one cycle
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_we && $stable(out_pix)));

  // R1: symbol 0 in robust mode keeps the pixel and does not strobe
  assert_keep_pixel_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_robust && wm_sym == 2'd0) |=> (out_pix == $past(pix_cur) && !out_we));

  // R6: fragile flip touches only the chosen plane and always strobes
  assert_fragile_plane_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_robust) |=>
      (out_we && ((out_pix ^ $past(pix_cur)) == (PIX_W'($past(wm_sym[0])) << PLANE))));

  // R5: clamped blend never drops below the scaled neighbourhood term
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_robust && (wm_sym == 2'd1 || wm_sym == 2'd2)) |=>
      (out_we && (NW'(out_pix) >= $past(n_term))));
endmodule

// File: tb/tb_wm_pixel_embed.sv
module tb_wm_pixel_embed;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, mode_robust;
  logic [1:0] wm_sym;
  logic [7:0] alpha1, alpha2_mag, pix_cur, pix_right, pix_below, pix_diag;
  logic       out_valid, out_we;
  logic [7:0] out_pix;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  wm_pixel_embed dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_robust(mode_robust),
    .wm_sym(wm_sym), .alpha1(alpha1), .alpha2_mag(alpha2_mag),
    .pix_cur(pix_cur), .pix_right(pix_right), .pix_below(pix_below),
    .pix_diag(pix_diag), .out_valid(out_valid), .out_we(out_we), .out_pix(out_pix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      done = 1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<50000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int nb_of(int r, int b, int d);
    return (((b + d) / 2) + r) / 2;
  endfunction

  function automatic int robust_val(int sym, int a1, int a2, int c, int r, int b, int d);
    int n, p, s;
    n = (nb_of(r, b, d) * (256 - a1)) / 256;
    p = (sym == 2) ? (c * a2) / 256 : (c * a1) / 256;
    s = n + p;
    return (s > 255) ? 255 : s;
  endfunction

  function automatic int exp_pix(bit mr, int sym, int a1, int a2, int c, int r, int b, int d);
    if (!mr) return c ^ ((sym & 1) << 2);
    if (sym == 1 || sym == 2) return robust_val(sym, a1, a2, c, r, b, d);
    return c;
  endfunction

  function automatic bit exp_we(bit mr, int sym);
    if (!mr) return 1'b1;
    return (sym == 1 || sym == 2);
  endfunction

  task automatic check(string tag, int act, int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one valid pixel at negedge, sample after the next posedge
  task automatic apply(string tag, bit mr, int sym, int a1, int a2,
                       int c, int r, int b, int d);
    int ep;
    bit ew;
    in_valid = 1'b1; mode_robust = mr; wm_sym = 2'(sym);
    alpha1 = 8'(a1); alpha2_mag = 8'(a2);
    pix_cur = 8'(c); pix_right = 8'(r); pix_below = 8'(b); pix_diag = 8'(d);
    ep = exp_pix(mr, sym, a1, a2, c, r, b, d);
    ew = exp_we(mr, sym);
    @(negedge clk);
    check({tag, " pix"}, int'(out_pix), ep);
    check({tag, " we"}, int'(out_we), int'(ew));
    check({tag, " valid R8"}, int'(out_valid), 1);
  endtask

  initial begin
    int last;
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 0; mode_robust = 0; wm_sym = 0;
    alpha1 = 0; alpha2_mag = 0; pix_cur = 0; pix_right = 0; pix_below = 0; pix_diag = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", int'(out_valid), 0);
    check("R10 we", int'(out_we), 0);
    check("R10 pix", int'(out_pix), 0);
    rst = 1'b0;

    // R2 mean: alpha1=0, pix_cur=0 shows the mean directly
    apply("R2 mean carry", 1, 1, 0, 0, 0, 0, 255, 255);
    check("R2 mean value", int'(out_pix), 127);
    apply("R2 mean floor", 1, 1, 0, 0, 0, 1, 1, 0);
    check("R2 mean floor value", int'(out_pix), 0);
    // R1 keep
    apply("R1 keep", 1, 0, 77, 99, 201, 3, 4, 5);
    // R3 add
    apply("R3 add", 1, 1, 128, 0, 200, 100, 50, 150);
    // R4 subtract of negative term
    apply("R4 sub", 1, 2, 64, 192, 180, 90, 30, 60);
    // R5 saturation
    apply("R5 sat", 1, 2, 0, 255, 255, 255, 255, 255);
    check("R5 sat value", int'(out_pix), 255);
    apply("R5 edge", 1, 1, 255, 0, 255, 255, 255, 255);
    // R9 reserved
    apply("R9 rsvd", 1, 3, 10, 20, 123, 1, 2, 3);
    // R6 / R7 fragile, wm_sym[1] ignored
    apply("R6 flip", 0, 1, 5, 5, 8'h00, 9, 9, 9);
    check("R6 flip value", int'(out_pix), 4);
    apply("R6 ignore hi", 0, 2, 5, 5, 8'hFF, 9, 9, 9);
    check("R6 ignore value", int'(out_pix), 255);
    apply("R7 same input robust", 1, 1, 0, 0, 8'h00, 9, 9, 9);
    check("R7 robust value", int'(out_pix), 9);

    // R8 idle: outputs quiet, pixel held
    last = int'(out_pix);
    in_valid = 1'b0; pix_cur = 8'hA5; mode_robust = 0;
    @(negedge clk);
    check("R8 idle valid", int'(out_valid), 0);
    check("R8 idle we", int'(out_we), 0);
    check("R8 idle hold", int'(out_pix), last);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int s, mr;
      mr = int'($urandom_range(0, 3) != 0);
      s = int'($urandom_range(0, 3));
      apply($sformatf("R3/R4/R6 rand %0d", k), bit'(mr), s,
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule